// File: doc/BRIEF.md
# Interrupt Source Pending Capture

This block turns a set of external interrupt wires into per-source, per-processor pending flags for a multi-processor interrupt controller. Each external wire is brought into the clock domain through a two-flop synchronizer, and a stored copy of its level is kept. When the synchronized level goes from low to high, the block records the new level. It then marks the source pending for every processor in that source's target mask, provided the source is configured edge-triggered or is enabled at that moment. A falling wire only updates the stored level.

Interrupt numbers below 32 belong to per-processor private sources. These have no wire here and become pending only through software. External wire n is interrupt number n + 32. Software can set or clear pending bits of any interrupt number for a mask of processors. The acknowledge logic of the arbiter drives a separate clear port. That clear removes the bit of one processor, or the bits of all processors when the source is marked one-of-N. When a set and a clear land on the same bit in the same cycle, the set wins. The pending and stored-level vectors feed the arbiter.

Top module: `irq_pend_capture`

## Requirements
- R1: External wire n drives the pending bits of interrupt number n + 32. The pending bit for interrupt i and processor c sits at pend_o[i*N_CPU + c].
- R2: A change on irq_i[n] shows on level_o[n] on the third rising clock edge after the change. Any pending bits it sets appear on that same edge, and neither output moves before it.
- R3: On a rising synchronized level of an edge-triggered source (edge flag 1), the pending bits of all processors selected in that source's target mask are set.
- R4: On a rising synchronized level of a level-triggered source (edge flag 0), pending bits are set only if the source's enable is 1 at that rise. Enabling the source later while the wire stays high sets nothing.
- R5: Processors outside a source's target mask never get that source's pending bit from its wire.
- R6: A falling wire clears level_o only. All pending bits keep their value.
- R7: A wire that stays high does not set pending again after its bits have been cleared. Only a new low-to-high change acts.
- R8: A software set writes 1 to the pending bits of sw_set_id_i for the processors in sw_set_mask_i. This works for private and external numbers alike, and a set of a bit that is already 1 leaves it 1.
- R9: A software clear writes 0 to the pending bits of sw_clr_id_i for the processors in sw_clr_mask_i. Other bits are untouched.
- R10: An acknowledge clear of a source whose model flag is 0 clears only processor ack_clr_cpu_i's bit. With model flag 1 it clears the bits of every processor for that source.
- R11: When a set and a clear hit the same bit in the same cycle, the bit ends up 1.
- R12: After reset all pending bits and all stored levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_EXT | External interrupt wires, asynchronous |
| cfg_enable_i | input | N_EXT | Enable per external source |
| cfg_edge_i | input | N_EXT | Trigger flag per external source, 1 = edge |
| cfg_model_i | input | N_IRQ | Model flag per source, 1 = one-of-N |
| cfg_target_i | input | N_EXT*N_CPU | Target mask per external source, bit n*N_CPU+c selects processor c |
| sw_set_valid_i | input | 1 | Software set-pending request |
| sw_set_id_i | input | ID_W | Interrupt number to set |
| sw_set_mask_i | input | N_CPU | Processors to set |
| sw_clr_valid_i | input | 1 | Software clear-pending request |
| sw_clr_id_i | input | ID_W | Interrupt number to clear |
| sw_clr_mask_i | input | N_CPU | Processors to clear |
| ack_clr_valid_i | input | 1 | Clear from acknowledge logic |
| ack_clr_id_i | input | ID_W | Acknowledged interrupt number |
| ack_clr_cpu_i | input | CPU_W | Acknowledging processor |
| pend_o | output | N_IRQ*N_CPU | Pending bits, interrupt-major |
| level_o | output | N_EXT | Stored synchronized level per external wire |

## Verification
The bench sweeps every external wire against every combination of trigger flag, enable and target mask. Each sweep step checks the outputs both one edge before and on the edge the change is due. This catches a design with the wrong synchronizer depth, a design that ignores the enable for level sources, and one that writes to processors outside the mask. It also clears pending while a wire is held high, which exposes a design that acts on level instead of change. It drops a wire that has pending set, which exposes a design whose fall clears pending. Software set and clear run over every interrupt number and mask. Acknowledge clears run with both model settings. Colliding set and clear requests must keep the bit, so a design that lets the clear win fails.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned EXT_BASE = 32;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  typedef enum logic {
    MODEL_N_N      = 1'b0,
    MODEL_ONE_OF_N = 1'b1
  } model_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned N_LINES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] level_o,
  output logic [N_LINES-1:0] rise_o
);
  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    logic s1_q, s2_q, lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        lvl_q <= 1'b0;
      end else begin
        s1_q  <= line_i[n];
        s2_q  <= s1_q;
        lvl_q <= s2_q;
      end
    end

    assign level_o[n] = lvl_q;
    assign rise_o[n]  = s2_q & ~lvl_q;

    // R2
    rise_sets_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[n] |=> level_o[n]);
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_BITS = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] set_i,
  input  logic [N_BITS-1:0] clr_i,
  output logic [N_BITS-1:0] pend_o
);
  logic [N_BITS-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= set_i | (pend_q & ~clr_i);  // set wins
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N_BITS; i++) begin : g_chk
    // R11
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_o[i]);
    // R8
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_o[i]) |-> $past(set_i[i]));
  end
endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture
  import irq_pend_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned N_CPU = 2,
  localparam int unsigned N_IRQ = EXT_BASE + N_EXT,
  localparam int unsigned ID_W  = $clog2(N_IRQ),
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_EXT-1:0]       irq_i,
  input  logic [N_EXT-1:0]       cfg_enable_i,
  input  logic [N_EXT-1:0]       cfg_edge_i,
  input  logic [N_IRQ-1:0]       cfg_model_i,
  input  logic [N_EXT*N_CPU-1:0] cfg_target_i,
  input  logic                   sw_set_valid_i,
  input  logic [ID_W-1:0]        sw_set_id_i,
  input  logic [N_CPU-1:0]       sw_set_mask_i,
  input  logic                   sw_clr_valid_i,
  input  logic [ID_W-1:0]        sw_clr_id_i,
  input  logic [N_CPU-1:0]       sw_clr_mask_i,
  input  logic                   ack_clr_valid_i,
  input  logic [ID_W-1:0]        ack_clr_id_i,
  input  logic [CPU_W-1:0]       ack_clr_cpu_i,
  output logic [N_IRQ*N_CPU-1:0] pend_o,
  output logic [N_EXT-1:0]       level_o
);
  localparam int unsigned N_BITS = N_IRQ * N_CPU;

  logic [N_EXT-1:0]  rise;
  logic [N_BITS-1:0] set_vec, clr_vec;

  irq_line_sync #(.N_LINES(N_EXT)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (irq_i),
    .level_o (level_o),
    .rise_o  (rise)
  );

  for (genvar id = 0; id < N_IRQ; id++) begin : g_id
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      localparam int unsigned I = id * N_CPU + c;
      logic hw_set, sw_set, sw_clr, ack_clr;

      if (id >= EXT_BASE) begin : g_ext
        localparam int unsigned E = id - EXT_BASE;
        assign hw_set = rise[E] && cfg_target_i[E*N_CPU+c]
                        && (cfg_edge_i[E] == TRIG_EDGE || cfg_enable_i[E]);

        // R4
        lvl_disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (rise[E] && cfg_edge_i[E] == TRIG_LEVEL && !cfg_enable_i[E]
           && !sw_set_valid_i && !pend_o[I]) |=> !pend_o[I]);
        // R6
        fall_keeps_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ($fell(level_o[E]) && !$past(sw_set_valid_i) && !$past(sw_clr_valid_i)
           && !$past(ack_clr_valid_i)) |-> $stable(pend_o[I]));
        // R5
        untargeted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (!cfg_target_i[E*N_CPU+c] && !sw_set_valid_i && !pend_o[I]) |=> !pend_o[I]);
      end else begin : g_priv
        assign hw_set = 1'b0;
      end

      assign sw_set  = sw_set_valid_i && sw_set_id_i == ID_W'(id) && sw_set_mask_i[c];
      assign sw_clr  = sw_clr_valid_i && sw_clr_id_i == ID_W'(id) && sw_clr_mask_i[c];
      assign ack_clr = ack_clr_valid_i && ack_clr_id_i == ID_W'(id)
                       && (cfg_model_i[id] == MODEL_ONE_OF_N || ack_clr_cpu_i == CPU_W'(c));

      assign set_vec[I] = hw_set | sw_set;
      assign clr_vec[I] = sw_clr | ack_clr;
    end
  end

  irq_pend_bank #(.N_BITS(N_BITS)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_o)
  );
endmodule

// File: tb/test_irq_pend_capture.sv
module test_irq_pend_capture;
  localparam int N_EXT = 4;
  localparam int N_CPU = 2;
  localparam int BASE  = 32;
  localparam int N_IRQ = BASE + N_EXT;
  localparam int ID_W  = 6;
  localparam int NB    = N_IRQ * N_CPU;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_EXT-1:0]       irq_i = '0;
  logic [N_EXT-1:0]       cfg_enable_i = '0;
  logic [N_EXT-1:0]       cfg_edge_i = '0;
  logic [N_IRQ-1:0]       cfg_model_i = '0;
  logic [N_EXT*N_CPU-1:0] cfg_target_i = '0;
  logic                   sw_set_valid_i = 1'b0;
  logic [ID_W-1:0]        sw_set_id_i = '0;
  logic [N_CPU-1:0]       sw_set_mask_i = '0;
  logic                   sw_clr_valid_i = 1'b0;
  logic [ID_W-1:0]        sw_clr_id_i = '0;
  logic [N_CPU-1:0]       sw_clr_mask_i = '0;
  logic                   ack_clr_valid_i = 1'b0;
  logic [ID_W-1:0]        ack_clr_id_i = '0;
  logic                   ack_clr_cpu_i = 1'b0;
  logic [NB-1:0]          pend_o;
  logic [N_EXT-1:0]       level_o;

  logic [NB-1:0]    exp_pend = '0;
  logic [N_EXT-1:0] exp_lvl = '0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_pend_capture #(.N_EXT(N_EXT), .N_CPU(N_CPU)) i_irq_pend_capture (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i),
    .cfg_enable_i(cfg_enable_i), .cfg_edge_i(cfg_edge_i),
    .cfg_model_i(cfg_model_i), .cfg_target_i(cfg_target_i),
    .sw_set_valid_i(sw_set_valid_i), .sw_set_id_i(sw_set_id_i), .sw_set_mask_i(sw_set_mask_i),
    .sw_clr_valid_i(sw_clr_valid_i), .sw_clr_id_i(sw_clr_id_i), .sw_clr_mask_i(sw_clr_mask_i),
    .ack_clr_valid_i(ack_clr_valid_i), .ack_clr_id_i(ack_clr_id_i), .ack_clr_cpu_i(ack_clr_cpu_i),
    .pend_o(pend_o), .level_o(level_o)
  );

  task automatic chk(input string tag);
    checks++;
    if (pend_o !== exp_pend || level_o !== exp_lvl) begin
      fails++;
      $display("FAIL %s pend=%h exp=%h level=%b exp=%b", tag, pend_o, exp_pend, level_o, exp_lvl);
    end
  endtask

  // one-cycle request; model applies set-over-clear rule
  task automatic req(input logic sv, input int sid, input logic [1:0] sm,
                     input logic cv, input int cid, input logic [1:0] cm,
                     input logic av, input int aid, input int acpu);
    logic [NB-1:0] s, c;
    sw_set_valid_i = sv;  sw_set_id_i = ID_W'(sid); sw_set_mask_i = sm;
    sw_clr_valid_i = cv;  sw_clr_id_i = ID_W'(cid); sw_clr_mask_i = cm;
    ack_clr_valid_i = av; ack_clr_id_i = ID_W'(aid); ack_clr_cpu_i = acpu[0];
    s = '0; c = '0;
    for (int p = 0; p < N_CPU; p++) begin
      if (sv && sm[p]) s[sid*N_CPU+p] = 1'b1;
      if (cv && cm[p]) c[cid*N_CPU+p] = 1'b1;
      if (av && (cfg_model_i[aid] || acpu == p)) c[aid*N_CPU+p] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    sw_set_valid_i = 1'b0; sw_clr_valid_i = 1'b0; ack_clr_valid_i = 1'b0;
    exp_pend = s | (exp_pend & ~c);
  endtask

  task automatic drive_line(input int e, input logic v, input string tag);
    irq_i[e] = v;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({tag, " R2 early"});
    @(posedge clk); @(negedge clk);
    if (v && !exp_lvl[e] && (cfg_edge_i[e] || cfg_enable_i[e]))
      for (int p = 0; p < N_CPU; p++)
        if (cfg_target_i[e*N_CPU+p]) exp_pend[(BASE+e)*N_CPU+p] = 1'b1;
    exp_lvl[e] = v;
    chk(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 after release");

    // wire sweep: line x trigger/enable x target
    for (int e = 0; e < N_EXT; e++)
      for (int cf = 0; cf < 4; cf++)
        for (int t = 0; t < 4; t++) begin
          cfg_edge_i = '0; cfg_enable_i = '0; cfg_target_i = '0;
          cfg_edge_i[e] = cf[0]; cfg_enable_i[e] = cf[1];
          cfg_target_i[e*N_CPU +: N_CPU] = t[1:0];
          @(negedge clk);
          drive_line(e, 1'b1, "R1 R3 R4 R5 rise");
          drive_line(e, 1'b0, "R6 fall");
          drive_line(e, 1'b1, "R3 second rise");
          req(0, 0, 0, 1, BASE+e, 2'b11, 0, 0, 0);
          repeat (4) @(negedge clk);
          chk("R7 held high");
          drive_line(e, 1'b0, "R6 fall clean");
        end

    // level source enabled while already high
    cfg_edge_i = '0; cfg_enable_i = '0; cfg_target_i = '1;
    @(negedge clk);
    drive_line(1, 1'b1, "R4 disabled rise");
    cfg_enable_i[1] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 late enable");
    drive_line(1, 1'b0, "R6 fall");
    cfg_enable_i = '0;

    // software set / clear over all numbers and masks
    for (int id = 0; id < N_IRQ; id++)
      for (int m = 1; m < 4; m++) begin
        req(1, id, m[1:0], 0, 0, 0, 0, 0, 0);
        chk("R8 sw set");
        req(1, id, m[1:0], 0, 0, 0, 0, 0, 0);
        chk("R8 sw set again");
        req(1, id, 2'b11, 0, 0, 0, 0, 0, 0);
        req(0, 0, 0, 1, id, m[1:0], 0, 0, 0);
        chk("R9 sw clear partial");
        req(0, 0, 0, 1, id, 2'b11, 0, 0, 0);
        chk("R9 sw clear all");
      end

    // acknowledge clear, both models
    for (int k = 0; k < 2; k++) begin
      int id = (k == 0) ? 5 : BASE + 2;
      for (int md = 0; md < 2; md++)
        for (int cpu = 0; cpu < N_CPU; cpu++) begin
          cfg_model_i[id] = md[0];
          req(1, id, 2'b11, 0, 0, 0, 0, 0, 0);
          req(0, 0, 0, 0, 0, 0, 1, id, cpu);
          chk("R10 ack clear");
          req(0, 0, 0, 1, id, 2'b11, 0, 0, 0);
        end
    end

    // set vs clear in the same cycle
    req(1, 7, 2'b11, 0, 0, 0, 0, 0, 0);
    req(1, 7, 2'b01, 1, 7, 2'b11, 0, 0, 0);
    chk("R11 set beats sw clear");
    cfg_model_i[BASE+3] = 1'b1;
    req(1, BASE+3, 2'b10, 0, 0, 0, 1, BASE+3, 0);
    chk("R11 set beats ack clear");
    req(1, 0, 2'b01, 1, 0, 2'b01, 1, 0, 0);
    chk("R11 set beats both clears");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule